// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

An 8-bit up-counter advanced by ticks from a free-running system-clock prescaler. A 3-bit select field picks one of eight prescaler taps. When the counter wraps from 0xFF to 0x00 it sets an overflow flag. In interval mode the flag raises an interrupt request. In watchdog mode the wrap also fires a fixed-length reset request pulse.

Two 8-bit registers sit behind a simple register port.

- The counter is at address 0.
- The control/status register is at address 1.

Reads return the plain byte. Writes are 16-bit words: the upper byte is a key that must match the target register, and the lower byte is the data. A hardware standby input forces the reset state. A software standby input freezes the prescaler and the counter but keeps every register.

Top module: `wdt_timer`

## Requirements
- R1: After reset, or in any cycle after `hw_stby` was high, the counter reads 0x00, the control/status register reads 0x18, and `ovf`, `irq` and `wdt_rst_req` are low.
- R2: While enabled, the counter adds one in each cycle in which the prescaler tap is hit. The prescaler is a 17-bit count that starts at zero after reset or hardware standby and advances once per clock. A tap of divisor 2^k is hit when the low k prescaler bits are all ones. Select codes 0 to 7 give k = 1, 6, 7, 9, 11, 13, 15 and 17.
- R3: A wrap from 0xFF to 0x00 caused by a tick sets the overflow flag, which is control/status bit 7.
- R4: While the enable bit is 0, the counter is held at 0x00, and keyed counter writes have no effect.
- R5: A keyed control/status write clears the flag when data bit 7 is 0. Data bit 7 equal to 1 leaves the flag as it was. An overflow in the same cycle as a clear leaves the flag at 1.
- R6: A counter write takes effect only when the upper byte is 0x5A. A control/status write takes effect only when the upper byte is 0xA5. Any other key changes nothing.
- R7: Control/status layout:
  - bit 7: flag
  - bit 6: mode, where 1 selects watchdog
  - bit 5: enable
  - bits 4 and 3: always read 1
  - bits 2 to 0: select code
- R8: A keyed counter write while enabled loads the data and suppresses any increment in that cycle.
- R9: In interval mode, `irq` is high exactly while the flag is 1 and the mode bit is 0.
- R10: An overflow in watchdog mode drives `wdt_rst_req` high for exactly 16 consecutive clocks, starting in the cycle the flag becomes 1.
- R11: While `sw_stby` is high, the prescaler and the counter hold their values and all registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby, forces reset state |
| sw_stby | input | 1 | Software standby, freezes counting |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 selects the counter, 1 selects the control/status register |
| wdata | input | 16 | Key in the upper byte, data in the lower byte |
| rdata | output | 8 | Read value of the addressed register |
| ovf | output | 1 | Overflow flag |
| irq | output | 1 | Interval interrupt request |
| wdt_rst_req | output | 1 | Watchdog reset request pulse |

## Verification
A wrong prescaler phase or tap shows up on `rdata` as a counter that advances one cycle early or late. Under select code 0 this is visible within two clocks of enabling. A corrupted flag or key check appears on `ovf`, `irq` or the read byte in the cycle after the write or wrap. A miscounted pulse length appears at the seventeenth clock after a watchdog overflow. The bench compares every port against a behavioural model on every clock, and it alternates the read address, so register drift is seen within two cycles.

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int DW        = 8,
  parameter int PS_W      = 17,
  parameter logic [7:0] KEY_CNT = 8'h5A,
  parameter logic [7:0] KEY_CSR = 8'hA5,
  parameter int PULSE_LEN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_stby,
  input  logic            sw_stby,
  input  logic            wr_en,
  input  logic            addr,
  input  logic [2*DW-1:0] wdata,
  output logic [DW-1:0]   rdata,
  output logic            ovf,
  output logic            irq,
  output logic            wdt_rst_req
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PS_W-1:0] presc;
  logic [DW-1:0]   cnt_q;
  logic            ovf_q, mode_q, en_q;
  logic [2:0]      cks_q;
  logic [PW-1:0]   pul_q;

  function automatic logic [4:0] tap_shift(input logic [2:0] c);
    case (c)
      3'd0: tap_shift = 5'd1;
      3'd1: tap_shift = 5'd6;
      3'd2: tap_shift = 5'd7;
      3'd3: tap_shift = 5'd9;
      3'd4: tap_shift = 5'd11;
      3'd5: tap_shift = 5'd13;
      3'd6: tap_shift = 5'd15;
      default: tap_shift = 5'd17;
    endcase
  endfunction

  logic [PS_W:0]   mask_w;
  logic [PS_W-1:0] mask;
  logic tick, wr_cnt, wr_csr, wrap;

  assign mask_w = ({{PS_W{1'b0}}, 1'b1} << tap_shift(cks_q)) - 1'b1;
  assign mask   = mask_w[PS_W-1:0];
  assign tick   = en_q && !sw_stby && ((presc & mask) == mask);
  assign wr_cnt = wr_en && !addr && (wdata[2*DW-1:DW] == KEY_CNT);
  assign wr_csr = wr_en &&  addr && (wdata[2*DW-1:DW] == KEY_CSR);
  assign wrap   = tick && !wr_cnt && (cnt_q == {DW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc  <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      mode_q <= 1'b0;
      en_q   <= 1'b0;
      cks_q  <= '0;
      pul_q  <= '0;
    end else if (hw_stby) begin
      presc  <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      mode_q <= 1'b0;
      en_q   <= 1'b0;
      cks_q  <= '0;
      pul_q  <= '0;
    end else begin
      if (!sw_stby) presc <= presc + 1'b1;

      if (!en_q)       cnt_q <= '0;
      else if (wr_cnt) cnt_q <= wdata[DW-1:0];
      else if (tick)   cnt_q <= cnt_q + 1'b1;

      if (wrap)                      ovf_q <= 1'b1;
      else if (wr_csr && !wdata[7])  ovf_q <= 1'b0;

      if (wr_csr) begin
        mode_q <= wdata[6];
        en_q   <= wdata[5];
        cks_q  <= wdata[2:0];
      end

      if (wrap && mode_q)    pul_q <= PW'(PULSE_LEN);
      else if (pul_q != '0)  pul_q <= pul_q - 1'b1;
    end
  end

  assign rdata       = addr ? DW'({ovf_q, mode_q, en_q, 2'b11, cks_q}) : cnt_q;
  assign ovf         = ovf_q;
  assign irq         = ovf_q && !mode_q;
  assign wdt_rst_req = (pul_q != '0);
endmodule

module wdt_timer_chk #(
  parameter int DW = 8,
  parameter logic [7:0] KEY_CSR = 8'hA5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hw_stby,
  input logic            wr_en,
  input logic            addr,
  input logic [2*DW-1:0] wdata,
  input logic [DW-1:0]   cnt_q,
  input logic            ovf_q,
  input logic            mode_q,
  input logic            en_q,
  input logic [2:0]      cks_q,
  input logic            rst_req
);
  a_r1_stby_init: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hw_stby) |-> (cnt_q == '0 && !ovf_q && !en_q && !mode_q && cks_q == 3'd0));

  a_r3_flag_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !$past(ovf_q)) |-> ($past(cnt_q) == {DW{1'b1}} && $past(en_q)));

  a_r4_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (cnt_q == '0));

  a_r6_csr_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && addr && wdata[2*DW-1:DW] == KEY_CSR) && !hw_stby)
      |=> $stable({mode_q, en_q, cks_q}));

  a_r10_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> (ovf_q && $past(mode_q)));
endmodule

bind wdt_timer wdt_timer_chk #(.DW(DW), .KEY_CSR(KEY_CSR)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .cnt_q(cnt_q), .ovf_q(ovf_q), .mode_q(mode_q), .en_q(en_q),
  .cks_q(cks_q), .rst_req(wdt_rst_req)
);

// File: tb/sim_wdt_timer.sv
`timescale 1ns/1ps
module sim_wdt_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0, hw_stby = 1'b0, sw_stby = 1'b0, wr_en = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [7:0] rdata;
  logic ovf, irq, wdt_rst_req;

  int checks = 0, errors = 0;
  string phase = "R1";
  logic rd_sel = 1'b0;

  always #2 clk = ~clk;

  wdt_timer u0 (.clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .ovf(ovf),
    .irq(irq), .wdt_rst_req(wdt_rst_req));

  int m_cnt, m_ovf, m_mode, m_en, m_cks, m_ps, m_pul;

  function automatic int shf(int c);
    case (c)
      0: return 1;   1: return 6;   2: return 7;   3: return 9;
      4: return 11;  5: return 13;  6: return 15;  default: return 17;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin : model
    int dv, tk, wc, ws, ev;
    if (!rst_n || hw_stby) begin
      m_cnt = 0; m_ovf = 0; m_mode = 0; m_en = 0; m_cks = 0; m_ps = 0; m_pul = 0;
    end else begin
      dv = 1 << shf(m_cks);
      tk = (!sw_stby && m_en && (m_ps % dv == dv - 1)) ? 1 : 0;
      wc = (wr_en && addr == 1'b0 && wdata[15:8] == 8'h5A) ? 1 : 0;
      ws = (wr_en && addr == 1'b1 && wdata[15:8] == 8'hA5) ? 1 : 0;
      ev = (tk && !wc && m_cnt == 255) ? 1 : 0;
      if (ev && m_mode) m_pul = 16; else if (m_pul > 0) m_pul--;
      if (!m_en) m_cnt = 0;
      else if (wc) m_cnt = wdata[7:0];
      else if (tk) m_cnt = (m_cnt + 1) % 256;
      if (ev) m_ovf = 1; else if (ws && !wdata[7]) m_ovf = 0;
      if (ws) begin m_mode = wdata[6]; m_en = wdata[5]; m_cks = wdata[2:0]; end
      if (!sw_stby) m_ps = (m_ps + 1) % 131072;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      check({phase, " rdata"}, rdata, addr ? {m_ovf[0], m_mode[0], m_en[0], 2'b11, m_cks[2:0]} : m_cnt);
      check({phase, " ovf"}, ovf, m_ovf);
      check({phase, " irq"}, irq, m_ovf && !m_mode);
      check({phase, " wdt_rst_req"}, wdt_rst_req, m_pul != 0);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0; rd_sel = ~rd_sel; addr = rd_sel;
    end
  endtask

  task automatic wr(logic a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    wr_en = 1'b0; addr = a; #0.5; v = rdata;
  endtask

  logic [7:0] v;
  int hi;

  initial begin
    #10000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R1";
    rd(1'b0, v); check("R1 cnt reset", v, 8'h00);
    rd(1'b1, v); check("R1 csr reset", v, 8'h18);

    phase = "R6";
    wr(1'b1, 16'h5A21);
    rd(1'b1, v); check("R6 csr wrong key", v, 8'h18);
    wr(1'b0, 16'hA533);
    rd(1'b0, v); check("R6 cnt wrong key", v, 8'h00);

    phase = "R7";
    wr(1'b1, 16'hA507);
    rd(1'b1, v); check("R7 layout", v, 8'h1F);

    phase = "R2";
    wr(1'b1, 16'hA520);
    idle(40);
    phase = "R8";
    wr(1'b0, 16'h5AF0);
    rd(1'b0, v); check("R8 load", v, 8'hF0);

    phase = "R3";
    idle(40);
    rd(1'b1, v); check("R3 flag set", v[7], 1);
    phase = "R9";
    check("R9 irq", irq, 1);

    phase = "R5";
    wr(1'b1, 16'hA5A0);
    rd(1'b1, v); check("R5 write one keeps", v[7], 1);
    wr(1'b1, 16'hA520);
    rd(1'b1, v); check("R5 clear", v[7], 0);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); wr_en = 1'b1; addr = 1'b1; wdata = 16'hA520;
    end
    wr_en = 1'b0;

    phase = "R4";
    wr(1'b1, 16'hA500);
    wr(1'b0, 16'h5A33);
    rd(1'b0, v); check("R4 held zero", v, 8'h00);
    idle(10);

    phase = "R10";
    wr(1'b1, 16'hA560);
    wr(1'b0, 16'h5AFE);
    hi = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); if (wdt_rst_req) hi++;
    end
    check("R10 pulse length", hi, 16);
    check("R10 irq off", irq, 0);

    phase = "R2";
    wr(1'b1, 16'hA521);
    idle(700);
    wr(1'b1, 16'hA522);
    idle(300);

    phase = "R11";
    @(negedge clk); sw_stby = 1'b1;
    rd(1'b0, v); hi = v;
    idle(200);
    rd(1'b0, v); check("R11 frozen", v, hi);
    @(negedge clk); sw_stby = 1'b0;
    idle(200);

    phase = "R1";
    @(negedge clk); hw_stby = 1'b1;
    @(negedge clk); hw_stby = 1'b0;
    rd(1'b1, v); check("R1 hw standby csr", v, 8'h18);
    rd(1'b0, v); check("R1 hw standby cnt", v, 8'h00);
    idle(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule